// File: doc/BRIEF.md
# Correctable-Error Address Capture Unit

This unit sits next to a RAM controller that corrects single-bit errors. Each time the controller flags a corrected error on an access, the unit records the byte address of that access, sets a status flag and drives an interrupt line high. The recorded address is aligned to the access size: halfword accesses drop address bit 0 and word accesses drop bits 1:0.

Software finds the recorded address at register offset 4. It acknowledges the event by writing zero to the status register at offset 0. While the flag is set, the unit keeps the first recorded address and ignores later errors. Once the flag is cleared, the next error is recorded as a new event. The register port is a simple strobe interface. A read returns its data one cycle after the strobe.

Top module: `ce_capture_unit`

## Requirements
- R1: After reset, the status flag is 0, the recorded address is 0 and `irq_o` is low. A read of offset 0 or offset 4 returns 0.
- R2: An error pulse while the flag is clear sets the flag at the next clock edge and records `acc_addr` aligned by `acc_size`. Encoding 0 is a byte (address kept). Encoding 1 is a halfword (bit 0 cleared). Encoding 2 is a word (bits 1:0 cleared).
- R3: A read with `reg_en`=1 and `reg_we`=0 loads `reg_rdata` at that clock edge. At offset 0, bit 0 holds the flag and all other bits are 0. At offset 4, the data holds the recorded address, zero-extended to the data width. `reg_rdata` holds its value between reads.
- R4: `irq_o` is high exactly while the flag is set. Once raised, it stays high until a clearing write.
- R5: While the flag is set, further error pulses do not change the recorded address.
- R6: A write of zero to offset 0 clears the flag and `irq_o` at that clock edge and re-arms capture. The recorded address keeps its value until the next capture.
- R7: A nonzero write to offset 0, and any write to any other offset, has no effect on the flag, the address or the interrupt.
- R8: If a clearing write and an error pulse arrive in the same cycle, the new error is recorded and the flag stays set.
- R9: Size encoding 3 is aligned as a word access.
- R10: A read of any offset other than 0 or 4 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the unit |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_off | input | REG_AW | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after a read strobe |
| err_pulse | input | 1 | Corrected-error indication for the current access |
| acc_addr | input | ADDR_W | Byte address of the current access |
| acc_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 treated as word |
| irq_o | output | 1 | Interrupt level, high while an event is pending |

## Verification
The bench builds the unit with ADDR_W=24, DATA_W=32 and REG_AW=4. This width mix lets the checks confirm that the upper eight read bits of the address register stay zero (R3). The 4-bit offset space leaves the unmapped offsets 8 and 12 open for reads and writes (R7, R10). Random addresses cover all 24 bits, and all four size codes give alignment cases, including the reserved code. Dense random error pulses make captures while the flag is set, and clear-plus-error collisions, occur many times.

// File: rtl/cec_pkg.sv
package cec_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int unsigned OFF_STATUS = 0;
  localparam int unsigned OFF_ADDR   = 4;
endpackage

// File: rtl/cec_rst_sync.sv
module cec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cec_align.sv
module cec_align
  import cec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    addr_o = addr_i;
    unique case (acc_size_e'(size_i))
      SZ_BYTE: addr_o = addr_i;
      SZ_HALF: addr_o[0] = 1'b0;
      SZ_WORD, SZ_RSVD: addr_o[1:0] = 2'b00;
      default: addr_o = addr_i;
    endcase
  end

  // R2, R9: a word-class access never yields an unaligned address
  always_comb begin
    if (size_i[1]) a_r9_word_aligned: assert (addr_o[1:0] == 2'b00 || $isunknown(size_i));
  end
endmodule

// File: rtl/cec_core.sv
module cec_core #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              flag_q, flag_d;
  logic [ADDR_W-1:0] addr_q;
  logic              cap_en;

  // capture is armed while the flag is clear, or when it is being cleared now
  assign cap_en = err_i && (!flag_q || clr_i);

  always_comb begin
    flag_d = flag_q;
    if (cap_en)     flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (cap_en) addr_q <= addr_i;
  end

  assign flag_o = flag_q;
  assign addr_o = addr_q;

  a_r2_capture_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (err_i && !flag_q) |=> flag_q);
  a_r5_hold_address: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> $stable(addr_q));
  a_r6_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !err_i) |=> !flag_q);
  a_r8_clear_with_error: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && err_i) |=> (flag_q && addr_q == $past(addr_i)));
endmodule

// File: rtl/cec_regs.sv
module cec_regs
  import cec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_off,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              flag_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [REG_AW-1:0] OffStat = REG_AW'(OFF_STATUS);
  localparam logic [REG_AW-1:0] OffAddr = REG_AW'(OFF_ADDR);

  logic              rd_en;
  logic [DATA_W-1:0] rdata_d, rdata_q, addr_ext;

  assign rd_en = reg_en && !reg_we;
  assign clr_o = reg_en && reg_we && (reg_off == OffStat) && (reg_wdata == '0);

  always_comb begin
    addr_ext = '0;
    addr_ext[ADDR_W-1:0] = addr_i;
  end

  always_comb begin
    rdata_d = '0;
    if (reg_off == OffStat)      rdata_d[0] = flag_i;
    else if (reg_off == OffAddr) rdata_d = addr_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_off != OffStat && reg_off != OffAddr) |=> (rdata_q == '0));
  a_r3_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_off == OffStat) |=> (rdata_q[DATA_W-1:1] == '0 && rdata_q[0] == $past(flag_i)));
  a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/ce_capture_unit.sv
module ce_capture_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_off,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              err_pulse,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  output logic              irq_o
);
  logic              rst_n_s;
  logic [ADDR_W-1:0] aligned_addr, cap_addr;
  logic              flag, clr;

  cec_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  cec_align #(.ADDR_W(ADDR_W)) u_align (
    .addr_i(acc_addr), .size_i(acc_size), .addr_o(aligned_addr)
  );

  cec_core #(.ADDR_W(ADDR_W)) u_core (
    .clk(clk), .rst_n(rst_n_s), .err_i(err_pulse), .addr_i(aligned_addr),
    .clr_i(clr), .flag_o(flag), .addr_o(cap_addr)
  );

  cec_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .reg_en(reg_en), .reg_we(reg_we),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .flag_i(flag), .addr_i(cap_addr),
    .clr_o(clr), .rdata_o(reg_rdata)
  );

  assign irq_o = flag;

  a_r4_irq_until_clear: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_o && !clr) |=> irq_o);
  a_r7_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_o && !(reg_en && reg_we)) |=> irq_o);
endmodule

// File: tb/sim_ce_capture_unit.sv
`timescale 1ns/1ps
module sim_ce_capture_unit;
  localparam int AW = 24;
  localparam int DW = 32;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_en, reg_we, err_pulse;
  logic [RW-1:0] reg_off;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic [AW-1:0] acc_addr;
  logic [1:0]    acc_size;
  logic          irq_o;

  int checks = 0;
  int errors = 0;

  logic          m_flag;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_rdata;

  always #10 clk = ~clk;

  ce_capture_unit #(.ADDR_W(AW), .DATA_W(DW), .REG_AW(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .err_pulse(err_pulse), .acc_addr(acc_addr), .acc_size(acc_size), .irq_o(irq_o)
  );

  function automatic logic [AW-1:0] exp_align(logic [AW-1:0] a, logic [1:0] s);
    logic [AW-1:0] r = a;
    if (s == 2'd1) r[0] = 1'b0;
    else if (s[1]) r[1:0] = 2'b00;
    return r;
  endfunction

  function automatic logic [DW-1:0] exp_read(logic [RW-1:0] off, logic f, logic [AW-1:0] a);
    logic [DW-1:0] r = '0;
    if (off == 4'd0) r[0] = f;
    else if (off == 4'd4) r[AW-1:0] = a;
    return r;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive after the falling edge, model at the rising edge
  task automatic cyc(logic e, logic [AW-1:0] a, logic [1:0] s,
                     logic en, logic we, logic [RW-1:0] off, logic [DW-1:0] wd);
    logic clr;
    @(negedge clk);
    err_pulse = e; acc_addr = a; acc_size = s;
    reg_en = en; reg_we = we; reg_off = off; reg_wdata = wd;
    @(posedge clk);
    clr = en && we && off == 4'd0 && wd == '0;
    if (en && !we) m_rdata = exp_read(off, m_flag, m_addr);
    if (e && (!m_flag || clr)) begin
      m_flag = 1'b1; m_addr = exp_align(a, s);
    end else if (clr) m_flag = 1'b0;
    #2;
    err_pulse = 1'b0; reg_en = 1'b0;
  endtask

  task automatic rd(string req, logic [RW-1:0] off);
    cyc(1'b0, '0, 2'd0, 1'b1, 1'b0, off, '0);
    check(req, reg_rdata, m_rdata);
  endtask

  task automatic check_irq(string req);
    check(req, {31'd0, irq_o}, {31'd0, m_flag});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 1'b0; reg_en = 0; reg_we = 0; reg_off = '0; reg_wdata = '0;
    err_pulse = 0; acc_addr = '0; acc_size = '0;
    m_flag = 0; m_addr = '0; m_rdata = '0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    check_irq("R1 irq");
    rd("R1 status", 4'd0);
    rd("R1 addr", 4'd4);

    // R2 byte capture, R3 read, R4 irq
    cyc(1'b1, 24'hABCDEF, 2'd0, 0, 0, '0, '0);
    check_irq("R4 irq raised");
    rd("R3 status flag", 4'd0);
    rd("R2 byte addr", 4'd4);
    // R5 further error ignored
    cyc(1'b1, 24'h123456, 2'd2, 0, 0, '0, '0);
    rd("R5 addr held", 4'd4);
    // R7 nonzero write / other offsets ignored
    cyc(1'b0, '0, 2'd0, 1, 1, 4'd0, 32'h1);
    cyc(1'b0, '0, 2'd0, 1, 1, 4'd4, 32'h0);
    cyc(1'b0, '0, 2'd0, 1, 1, 4'd8, 32'h0);
    check_irq("R7 irq kept");
    rd("R7 addr kept", 4'd4);
    // R6 clear
    cyc(1'b0, '0, 2'd0, 1, 1, 4'd0, 32'h0);
    check_irq("R6 irq cleared");
    rd("R6 status cleared", 4'd0);
    rd("R6 addr retained", 4'd4);
    // R2 halfword, R9 reserved size
    cyc(1'b1, 24'h00FF37, 2'd1, 0, 0, '0, '0);
    rd("R2 half addr", 4'd4);
    cyc(1'b0, '0, 2'd0, 1, 1, 4'd0, 32'h0);
    cyc(1'b1, 24'h00FF37, 2'd3, 0, 0, '0, '0);
    rd("R9 reserved size addr", 4'd4);
    // R8 clear and error together
    cyc(1'b1, 24'hFFFFFE, 2'd2, 1, 1, 4'd0, 32'h0);
    check_irq("R8 irq stays");
    rd("R8 new addr", 4'd4);
    // R10 unmapped reads
    rd("R10 off 8", 4'd8);
    rd("R10 off 12", 4'd12);
    rd("R10 off 2", 4'd2);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic e, en, we;
      logic [RW-1:0] off;
      logic [DW-1:0] wd;
      e   = ($urandom % 3) == 0;
      en  = ($urandom % 2) == 0;
      we  = $urandom % 2;
      off = ($urandom % 2) ? 4'd0 : RW'($urandom % 16);
      wd  = ($urandom % 3) == 0 ? 32'($urandom) : 32'h0;
      cyc(e, AW'($urandom), 2'($urandom), en, we, off, wd);
      check_irq("R4 random irq");
      if (en && !we) check("R3 random read", reg_rdata, m_rdata);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule